// File: doc/BRIEF.md
# Parallel Display Bus Access Sequencer

This block drives a bidirectional 8080-style parallel bus toward a display module that keeps its own frame memory. One request on a valid/ready port becomes one bus access: a command write, a data write or a data read. The block produces per-profile chip-select lines, a write strobe, a read strobe and a command/data select line, and drives or samples a 16-bit data word. Every strobe edge sits at a programmed tick offset from the start of the access. A tick lasts one or two input clocks.

Two timing profiles are held side by side. Each profile has a packed edge word, a packed cycle word and a mode word. A profile-select input picks which profile, and therefore which chip-select line, serves the next request. Before use, the raw fields are forced into a consistent set: no strobe can come out zero-width or outlast its access. The whole effective timing is captured when a request is accepted.

Top module: `pbus_timing_engine`

## Requirements
- R1: While reset is low and right after it, no access is in progress: `req_ready` is high when the profile select is 1 or 2, `rd_valid` and `bus_oe` are low, write and read strobes and chip-selects sit at their inactive level, and `bus_dc` sits at the data level.
- R2: Counting ticks from 0 at acceptance, chip-select is asserted for ticks in [cs_on, cs_off). The write strobe is asserted in [we_on, we_off) for command and data writes only. The read strobe is asserted in [re_on, re_off) for reads only. Edge word layout: cs_on bits 3:0, cs_off bits 9:4, we_on bits 13:10, we_off bits 19:14, re_on bits 23:20, re_off bits 29:24.
- R3: Mode bit 0 sets the tick length: 0 gives one input clock per tick, 1 gives two.
- R4: Effective offsets: we_off' = we_off if above we_on, else we_on+1. re_off' follows the same rule. cs_off' = max(cs_off, cs_on+1, we_off', re_off'). The access time' = access time if above re_on, else re_on+1.
- R5: A write lasts max(we_cycle, cs_off') ticks. A read lasts max(re_cycle, cs_off', access time'+1) ticks. Cycle word layout: we_cycle bits 5:0, re_cycle bits 11:6, access time bits 27:22; bits 21:12 and 31:28 are ignored. `req_ready` is low while an access runs and high again on the clock after its last tick.
- R6: For a read, `bus_din` is captured at the end of the first input clock of tick access time'. `rd_valid` is high for exactly the following clock, with the captured word on `rd_data`.
- R7: Profile select value 1 routes the access to `bus_cs[0]` with profile 0 timing. Value 2 routes it to `bus_cs[1]` with profile 1 timing. Values 0 and 3 hold `req_ready` low and start no access.
- R8: `bus_dc` is at the command level (0 before polarity) during a command write (req_kind 0). It is at the data level (1 before polarity) during data writes (req_kind 1 or 3), during reads (req_kind 2) and when idle.
- R9: Mode bit 1 inverts `bus_dc`, bit 2 inverts `bus_re`, bit 3 inverts `bus_we` and bit 4 inverts that profile's chip-select. A cleared bit leaves the line uninverted, so 1 means asserted.
- R10: During a write access, `bus_oe` is high and `bus_dout` carries the accepted word. During a read access and when idle, `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_onoff | input | 64 | Edge words, profile p at bits 32p+31:32p |
| cfg_cycle | input | 64 | Cycle words, profile p at bits 32p+31:32p |
| cfg_mode | input | 10 | Mode words, 5 bits per profile (tick length, polarities) |
| prof_sel | input | 2 | Active profile select: 1, 2, or 0/3 for none |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on a clock where valid and ready are both high |
| req_kind | input | 2 | 0 command write, 1 or 3 data write, 2 read |
| req_wdata | input | 16 | Word to write |
| rd_valid | output | 1 | One-clock pulse when read data is captured |
| rd_data | output | 16 | Captured read word |
| bus_cs | output | 2 | Chip-select per profile |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_dc | output | 1 | Command/data select |
| bus_dout | output | 16 | Outgoing bus word |
| bus_oe | output | 1 | Bus drive enable for writes |
| bus_din | input | 16 | Incoming bus word |

## Verification
A wrong tick counter or sub-tick phase moves a strobe edge at the ports in the very clock it goes wrong. The bench compares every line on every clock of an access, so that error is caught at once. A bad clamp shows as a strobe that is missing or placed wrongly, or as `req_ready` coming back a tick early or late, within one access. A wrong capture phase returns the wrong word, or pulses `rd_valid` in a clock other than the predicted one.

// File: rtl/pbe_pkg.sv
package pbe_pkg;

    // raw field widths of the packed timing words
    localparam int ON_W   = 4;
    localparam int OFF_W  = 6;
    localparam int CYC_W  = 6;
    // widened counter width: a read can last up to 64 ticks
    localparam int CNT_W  = 7;
    localparam int WORD_W = 32;

    // mode word bit positions
    localparam int MODE_W  = 5;
    localparam int MB_GRAN = 0;
    localparam int MB_DC   = 1;
    localparam int MB_RE   = 2;
    localparam int MB_WE   = 3;
    localparam int MB_CS   = 4;

    typedef enum logic [1:0] {
        ACC_CMD      = 2'd0,
        ACC_DATA     = 2'd1,
        ACC_READ     = 2'd2,
        ACC_DATA_ALT = 2'd3
    } acc_kind_e;

    // strobe edges in ticks, already made consistent
    typedef struct packed {
        logic [CNT_W-1:0] cs_on;
        logic [CNT_W-1:0] cs_off;
        logic [CNT_W-1:0] we_on;
        logic [CNT_W-1:0] we_off;
        logic [CNT_W-1:0] re_on;
        logic [CNT_W-1:0] re_off;
    } edge_t;

    // access lengths and read sample point in ticks
    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] we_len;
        logic [CNT_W-1:0] re_len;
    } len_t;

    typedef struct packed {
        edge_t e;
        len_t  l;
    } win_t;

    function automatic logic [CNT_W-1:0] umax(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic in_span(input logic [CNT_W-1:0] t,
                                     input logic [CNT_W-1:0] lo,
                                     input logic [CNT_W-1:0] hi);
        return (t >= lo) && (t < hi);
    endfunction

endpackage

// File: rtl/pbe_win_clamp.sv
module pbe_win_clamp
    import pbe_pkg::*;
(
    input  logic [WORD_W-1:0] onoff_word,
    input  logic [WORD_W-1:0] cycle_word,
    output win_t              win
);

    localparam int ZON  = CNT_W - ON_W;
    localparam int ZOFF = CNT_W - OFF_W;
    localparam int ZCYC = CNT_W - CYC_W;

    logic [CNT_W-1:0] raw_cs_on, raw_cs_off, raw_we_on, raw_we_off;
    logic [CNT_W-1:0] raw_re_on, raw_re_off, raw_we_cyc, raw_re_cyc, raw_acc;
    logic [CNT_W-1:0] we_off_e, re_off_e, cs_off_e, acc_e;
    logic             unused_bits;

    // field extraction; positions are fixed by the packed word layout
    assign raw_cs_on  = {{ZON{1'b0}},  onoff_word[3:0]};
    assign raw_cs_off = {{ZOFF{1'b0}}, onoff_word[9:4]};
    assign raw_we_on  = {{ZON{1'b0}},  onoff_word[13:10]};
    assign raw_we_off = {{ZOFF{1'b0}}, onoff_word[19:14]};
    assign raw_re_on  = {{ZON{1'b0}},  onoff_word[23:20]};
    assign raw_re_off = {{ZOFF{1'b0}}, onoff_word[29:24]};
    assign raw_we_cyc = {{ZCYC{1'b0}}, cycle_word[5:0]};
    assign raw_re_cyc = {{ZCYC{1'b0}}, cycle_word[11:6]};
    assign raw_acc    = {{ZCYC{1'b0}}, cycle_word[27:22]};

    assign unused_bits = ^{onoff_word[31:30], cycle_word[21:12], cycle_word[31:28]};

    always_comb begin
        we_off_e = (raw_we_off > raw_we_on) ? raw_we_off : raw_we_on + 1'b1;
        re_off_e = (raw_re_off > raw_re_on) ? raw_re_off : raw_re_on + 1'b1;
        cs_off_e = umax(umax(raw_cs_off, raw_cs_on + 1'b1), umax(we_off_e, re_off_e));
        acc_e    = (raw_acc > raw_re_on) ? raw_acc : raw_re_on + 1'b1;

        win.e.cs_on  = raw_cs_on;
        win.e.cs_off = cs_off_e;
        win.e.we_on  = raw_we_on;
        win.e.we_off = we_off_e;
        win.e.re_on  = raw_re_on;
        win.e.re_off = re_off_e;
        win.l.acc    = acc_e;
        win.l.we_len = umax(raw_we_cyc, cs_off_e);
        win.l.re_len = umax(umax(raw_re_cyc, cs_off_e), acc_e + 1'b1);
    end

endmodule

// File: rtl/pbe_access_seq.sv
module pbe_access_seq
    import pbe_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IDXW = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [DW-1:0]    req_wdata,
    input  logic             sel_ok,
    input  logic [IDXW-1:0]  sel_idx,
    input  win_t             sel_win,
    input  logic             sel_gran,
    input  logic [2:0]       sel_pol,
    input  logic [DW-1:0]    bus_din,
    output logic             req_ready,
    output logic             busy,
    output logic [CNT_W-1:0] tick,
    output acc_kind_e        kind,
    output logic [IDXW-1:0]  idx,
    output edge_t            edges,
    output logic [2:0]       pol,
    output logic [DW-1:0]    wdata,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);

    typedef struct packed {
        logic             busy;
        logic             sub;
        logic [CNT_W-1:0] tick;
        acc_kind_e        kind;
        logic [IDXW-1:0]  idx;
        win_t             win;
        logic             gran;
        logic [2:0]       pol;
        logic [DW-1:0]    wdata;
        logic             rd_valid;
        logic [DW-1:0]    rd_data;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    logic             tick_en;
    logic [CNT_W-1:0] last;

    assign req_ready = !st_q.busy && sel_ok;
    assign tick_en   = !st_q.gran || st_q.sub;
    assign last      = (st_q.kind == ACC_READ) ? st_q.win.l.re_len : st_q.win.l.we_len;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        if (!st_q.busy) begin
            if (req_valid && req_ready) begin
                st_d.busy  = 1'b1;
                st_d.sub   = 1'b0;
                st_d.tick  = '0;
                st_d.kind  = acc_kind_e'(req_kind);
                st_d.idx   = sel_idx;
                st_d.win   = sel_win;
                st_d.gran  = sel_gran;
                st_d.pol   = sel_pol;
                st_d.wdata = req_wdata;
            end
        end else begin
            // sample in the first input clock of the access-time tick
            if (st_q.kind == ACC_READ && st_q.tick == st_q.win.l.acc && !st_q.sub) begin
                st_d.rd_valid = 1'b1;
                st_d.rd_data  = bus_din;
            end
            if (st_q.gran) begin
                st_d.sub = !st_q.sub;
            end
            if (tick_en) begin
                if (st_q.tick == last - 1'b1) begin
                    st_d.busy = 1'b0;
                    st_d.tick = '0;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign tick     = st_q.tick;
    assign kind     = st_q.kind;
    assign idx      = st_q.idx;
    assign edges    = st_q.win.e;
    assign pol      = st_q.pol;
    assign wdata    = st_q.wdata;
    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

    // R5
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (st_q.busy && st_q.tick == '0 && !st_q.sub));

    // R5
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.tick < last));

    // R3
    gran_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.gran && !st_q.sub) |=> (st_q.busy && $stable(st_q.tick)));

    // R6
    rd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd_valid |-> (st_q.kind == ACC_READ));

endmodule

// File: rtl/pbe_strobe_gen.sv
module pbe_strobe_gen
    import pbe_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NPROF = 2,
    parameter int IDXW  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic [CNT_W-1:0] tick,
    input  acc_kind_e        kind,
    input  logic [IDXW-1:0]  idx,
    input  edge_t            edges,
    input  logic [2:0]       pol,     // {we, re, dc}
    input  logic [NPROF-1:0] cs_pol,
    input  logic [DW-1:0]    wdata,
    output logic [NPROF-1:0] bus_cs,
    output logic             bus_we,
    output logic             bus_re,
    output logic             bus_dc,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_oe
);

    logic             cs_hit, we_int, re_int, dc_int, is_write;
    logic [NPROF-1:0] cs_int;

    assign is_write = busy && (kind != ACC_READ);
    assign cs_hit   = busy && in_span(tick, edges.cs_on, edges.cs_off);
    assign we_int   = is_write && in_span(tick, edges.we_on, edges.we_off);
    assign re_int   = busy && (kind == ACC_READ) && in_span(tick, edges.re_on, edges.re_off);
    assign dc_int   = !(busy && kind == ACC_CMD);

    for (genvar p = 0; p < NPROF; p++) begin : g_cs
        assign cs_int[p] = cs_hit && (idx == IDXW'(p));
        assign bus_cs[p] = cs_int[p] ^ cs_pol[p];
    end

    assign bus_we   = we_int ^ pol[2];
    assign bus_re   = re_int ^ pol[1];
    assign bus_dc   = dc_int ^ pol[0];
    assign bus_oe   = is_write;
    assign bus_dout = wdata;

    // R2
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_int && re_int));

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_int));

endmodule

// File: rtl/pbus_timing_engine.sv
module pbus_timing_engine
    import pbe_pkg::*;
#(
    parameter  int NPROF = 2,
    parameter  int DW    = 16,
    localparam int SELW  = $clog2(NPROF + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPROF*WORD_W-1:0] cfg_onoff,
    input  logic [NPROF*WORD_W-1:0] cfg_cycle,
    input  logic [NPROF*MODE_W-1:0] cfg_mode,
    input  logic [SELW-1:0]         prof_sel,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_kind,
    input  logic [DW-1:0]           req_wdata,
    output logic                    rd_valid,
    output logic [DW-1:0]           rd_data,
    output logic [NPROF-1:0]        bus_cs,
    output logic                    bus_we,
    output logic                    bus_re,
    output logic                    bus_dc,
    output logic [DW-1:0]           bus_dout,
    output logic                    bus_oe,
    input  logic [DW-1:0]           bus_din
);

    localparam int IDXW = (NPROF > 1) ? $clog2(NPROF) : 1;

    win_t              win_arr  [NPROF];
    logic [MODE_W-1:0] mode_arr [NPROF];
    logic [NPROF-1:0]  cs_pol;
    logic              sel_ok;
    logic [IDXW-1:0]   sel_idx;
    logic [MODE_W-1:0] sel_mode;

    for (genvar p = 0; p < NPROF; p++) begin : g_prof
        assign mode_arr[p] = cfg_mode[p*MODE_W +: MODE_W];
        assign cs_pol[p]   = mode_arr[p][MB_CS];
        pbe_win_clamp u_clamp (
            .onoff_word (cfg_onoff[p*WORD_W +: WORD_W]),
            .cycle_word (cfg_cycle[p*WORD_W +: WORD_W]),
            .win        (win_arr[p])
        );
    end

    // select value v in 1..NPROF picks profile v-1
    assign sel_ok   = (prof_sel != '0) && (int'(prof_sel) <= NPROF);
    assign sel_idx  = IDXW'(prof_sel - SELW'(1));
    assign sel_mode = mode_arr[sel_idx];

    logic             busy;
    logic [CNT_W-1:0] tick;
    acc_kind_e        kind;
    logic [IDXW-1:0]  idx;
    edge_t            edges;
    logic [2:0]       pol;
    logic [DW-1:0]    wdata;

    pbe_access_seq #(.DW(DW), .IDXW(IDXW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .sel_ok    (sel_ok),
        .sel_idx   (sel_idx),
        .sel_win   (win_arr[sel_idx]),
        .sel_gran  (sel_mode[MB_GRAN]),
        .sel_pol   ({sel_mode[MB_WE], sel_mode[MB_RE], sel_mode[MB_DC]}),
        .bus_din   (bus_din),
        .req_ready (req_ready),
        .busy      (busy),
        .tick      (tick),
        .kind      (kind),
        .idx       (idx),
        .edges     (edges),
        .pol       (pol),
        .wdata     (wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    pbe_strobe_gen #(.DW(DW), .NPROF(NPROF), .IDXW(IDXW)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .tick     (tick),
        .kind     (kind),
        .idx      (idx),
        .edges    (edges),
        .pol      (pol),
        .cs_pol   (cs_pol),
        .wdata    (wdata),
        .bus_cs   (bus_cs),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_dc   (bus_dc),
        .bus_dout (bus_dout),
        .bus_oe   (bus_oe)
    );

endmodule

// File: tb/pbus_timing_engine_tb_top.sv
`timescale 1ns/1ps
module pbus_timing_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] onoff_b [2];
    logic [31:0] cyc_b   [2];
    logic [4:0]  mode_b  [2];
    logic [1:0]  prof_sel = 2'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [1:0]  bus_cs;
    logic        bus_we, bus_re, bus_dc, bus_oe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = 16'h0;

    // raw field values kept per profile for the expectation model
    int f_cson[2], f_csoff[2], f_weon[2], f_weoff[2], f_reon[2], f_reoff[2];
    int f_wecyc[2], f_recyc[2], f_acc[2];

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur   = "R1";
    bit    done  = 1'b0;

    always #2.5 clk = ~clk;

    pbus_timing_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_onoff ({onoff_b[1], onoff_b[0]}),
        .cfg_cycle ({cyc_b[1], cyc_b[0]}),
        .cfg_mode  ({mode_b[1], mode_b[0]}),
        .prof_sel  (prof_sel),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_dc    (bus_dc),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .bus_din   (bus_din)
    );

    typedef struct {
        logic [1:0]  cs;
        logic        we, re, dc, oe, rdy, rdv;
        logic [15:0] dout, rdd;
    } exp_t;

    exp_t expq[$];

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %h expected %h at %0t", tag, cur, what, act, expv, $time);
        end
    endtask

    task automatic set_prof(input int p, input int cson, input int csoff, input int weon,
                            input int weoff, input int reon, input int reoff,
                            input int wecyc, input int recyc, input int acc, input logic [4:0] md);
        f_cson[p] = cson;   f_csoff[p] = csoff;
        f_weon[p] = weon;   f_weoff[p] = weoff;
        f_reon[p] = reon;   f_reoff[p] = reoff;
        f_wecyc[p] = wecyc; f_recyc[p] = recyc; f_acc[p] = acc;
        onoff_b[p] = 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) |
                     (32'(weoff) << 14) | (32'(reon) << 20) | (32'(reoff) << 24);
        // bits 17:12 carry a value that must have no effect (R5)
        cyc_b[p]   = 32'(wecyc) | (32'(recyc) << 6) | (32'h2A << 12) | (32'(acc) << 22);
        mode_b[p]  = md;
    endtask

    // one access: push one expectation per clock, then the idle clock after
    task automatic run_access(input int selv, input int kind, input logic [15:0] wd);
        int p, m, n, len, t;
        int cson, csoff, weon, weoff, reon, reoff, acc, wlen, rlen;
        bit busy, rd;
        exp_t e;
        p = selv - 1;
        // R4 clamp rules
        cson  = f_cson[p];
        weon  = f_weon[p];
        reon  = f_reon[p];
        weoff = (f_weoff[p] > weon) ? f_weoff[p] : weon + 1;
        reoff = (f_reoff[p] > reon) ? f_reoff[p] : reon + 1;
        csoff = imax(imax(f_csoff[p], cson + 1), imax(weoff, reoff));
        acc   = (f_acc[p] > reon) ? f_acc[p] : reon + 1;
        // R5 lengths
        wlen  = imax(f_wecyc[p], csoff);
        rlen  = imax(imax(f_recyc[p], csoff), acc + 1);
        rd    = (kind == 2);
        m     = 1 + int'(mode_b[p][0]);
        len   = rd ? rlen : wlen;
        n     = len * m;

        @(negedge clk);
        prof_sel  = 2'(selv);
        req_kind  = 2'(kind);
        req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= n; k++) begin
            busy   = (k < n);
            t      = k / m;
            for (int i = 0; i < 2; i++)
                e.cs[i] = (busy && i == p && t >= cson && t < csoff) ^ mode_b[i][4];
            e.we   = (busy && !rd && t >= weon && t < weoff) ^ mode_b[p][3];
            e.re   = (busy && rd && t >= reon && t < reoff) ^ mode_b[p][2];
            e.dc   = !(busy && kind == 0) ^ mode_b[p][1];
            e.oe   = busy && !rd;
            e.dout = wd;
            e.rdy  = !busy;
            e.rdv  = rd && (k == acc * m + 1);
            e.rdd  = bus_din;
            expq.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #2;
    endtask

    // scoreboard monitor: one expectation per clock while any are queued
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                cmp("R2 R7 R9", "bus_cs", 16'(bus_cs), 16'(e.cs));
                cmp("R2 R9", "bus_we", 16'(bus_we), 16'(e.we));
                cmp("R2 R9", "bus_re", 16'(bus_re), 16'(e.re));
                cmp("R8 R9", "bus_dc", 16'(bus_dc), 16'(e.dc));
                cmp("R10", "bus_oe", 16'(bus_oe), 16'(e.oe));
                if (e.oe) cmp("R10", "bus_dout", bus_dout, e.dout);
                cmp("R5", "req_ready", 16'(req_ready), 16'(e.rdy));
                cmp("R6", "rd_valid", 16'(rd_valid), 16'(e.rdv));
                if (e.rdv) cmp("R6", "rd_data", rd_data, e.rdd);
            end
        end
    end

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            report();
        end
    end

    task automatic no_sel_check(input logic [1:0] s);
        @(negedge clk);
        prof_sel  = s;
        req_kind  = 2'd1;
        req_valid = 1'b1;
        repeat (3) begin
            @(posedge clk);
            #1;
            // R7: no profile selected means no acceptance and no bus activity
            cmp("R7", "req_ready", 16'(req_ready), 16'h0);
            cmp("R7", "bus_oe", 16'(bus_oe), 16'h0);
            cmp("R7", "bus_cs", 16'(bus_cs), 16'({mode_b[1][4], mode_b[0][4]}));
        end
        @(negedge clk);
        req_valid = 1'b0;
        prof_sel  = 2'd1;
    endtask

    initial begin
        set_prof(0, 1, 9, 2, 6, 2, 7, 10, 11, 5, 5'b00000);
        set_prof(1, 0, 5, 1, 3, 1, 4, 6, 6, 3, 5'b00001);
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        cmp("R1", "req_ready", 16'(req_ready), 16'h1);
        cmp("R1", "rd_valid", 16'(rd_valid), 16'h0);
        cmp("R1", "bus_oe", 16'(bus_oe), 16'h0);
        cmp("R1", "bus_cs", 16'(bus_cs), 16'h0);
        cmp("R1", "bus_we", 16'(bus_we), 16'h0);
        cmp("R1", "bus_re", 16'(bus_re), 16'h0);
        cmp("R1", "bus_dc", 16'(bus_dc), 16'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        cmp("R1", "req_ready after release", 16'(req_ready), 16'h1);
        cmp("R1", "bus_cs after release", 16'(bus_cs), 16'h0);

        // R2 R8 R10: command then data write on profile 0, back to back
        cur = "R2 R8 cmd";
        run_access(1, 0, 16'h00A5);
        cur = "R8 R10 data";
        run_access(1, 1, 16'h1234);
        run_access(1, 3, 16'hC0DE);

        // R6: read on profile 0
        cur = "R6 read";
        bus_din = 16'hBEEF;
        run_access(1, 2, 16'h0);

        // R3 R7: profile 1 with two-clock ticks
        cur = "R3 R7 profile1";
        run_access(2, 1, 16'h5A5A);
        bus_din = 16'h7E81;
        run_access(2, 2, 16'h0);
        run_access(2, 0, 16'h0042);

        // R4: inconsistent fields on profile 0 get clamped
        cur = "R4 clamp";
        set_prof(0, 6, 2, 4, 4, 5, 1, 1, 2, 3, 5'b00000);
        run_access(1, 1, 16'h0F0F);
        bus_din = 16'h3C3C;
        run_access(1, 2, 16'h0);   // sample falls in the last tick
        run_access(1, 0, 16'h0001);

        // R9: inverted polarities on both profiles
        cur = "R9 polarity";
        set_prof(0, 0, 4, 1, 3, 1, 3, 5, 6, 2, 5'b11110);
        set_prof(1, 2, 3, 0, 2, 3, 5, 2, 4, 1, 5'b10011);
        #5;
        run_access(1, 0, 16'hAAAA);
        bus_din = 16'h9009;
        run_access(1, 2, 16'h0);
        run_access(2, 1, 16'h5555);
        bus_din = 16'h1FF1;
        run_access(2, 2, 16'h0);   // R4 lengthens this read to cover the sample

        // R7: select values that choose no profile
        cur = "R7 no select";
        no_sel_check(2'd0);
        no_sel_check(2'd3);
        cur = "R7 resume";
        run_access(1, 1, 16'h7777);

        repeat (4) @(posedge clk);
        done = 1'b1;
        report();
    end

endmodule